// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one accepted burst request into the run of column addresses that a DRAM read or write burst visits. A request carries only a starting column; the burst length (2, 4 or 8 beats) and the ordering mode (sequential or interleaved) come from a configuration held inside the block. That configuration is loaded from a mode-register load word, the same word a controller issues to the memory, so both sides agree on the burst shape.

For each beat the block presents a column address, a valid flag and a last-beat flag. The column bits above the burst's aligned block stay fixed, and only the low offset bits step. Sequential mode counts up from the start offset and wraps inside the block. Interleaved mode uses the start offset XORed with the beat index.

Both the request input and the beat output are valid/ready streams. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` stays low while a burst is running. A beat is consumed on an edge where `beat_valid` and `beat_ready` are both high. While `beat_ready` is low, the presented beat is held unchanged.

Top module: `burst_col_seq`

## Requirements
- R1: After reset `beat_valid` is 0, `req_ready` is 1, `busy` is 0 and `cfg_err` is 0. The configuration is length 8, sequential.
- R2: A request accepted on one edge makes `beat_valid` high from the next cycle. From then until the burst ends, `busy` is 1 and `req_ready` is 0.
- R3: In sequential mode (mode word bit 3 = 0) beat i carries offset (start offset + i) modulo L.
- R4: In interleaved mode (mode word bit 3 = 1) beat i carries offset start offset XOR i.
- R5: The offset is column bit 0 for L=2, bits 1:0 for L=4 and bits 2:0 for L=8. Every column bit above the offset equals the request's bit for the whole burst.
- R6: A burst delivers exactly L beats. `beat_last` is 1 on the final beat only, and `beat_valid` drops in the cycle after that beat is consumed.
- R7: While `beat_valid` is 1 and `beat_ready` is 0, `beat_col` and `beat_last` hold their values into the next cycle.
- R8: A mode load with bank select 00 and length code 001, 010 or 011 (bits 2:0, meaning L=2, 4 or 8) replaces the length and the mode from bit 3. It applies to the next accepted request.
- R9: A mode load with bank select 00 and any other length code raises `cfg_err` for one cycle and leaves the configuration unchanged.
- R10: A mode load with a nonzero bank select leaves the configuration unchanged and does not raise `cfg_err`.
- R11: A request presented while a burst is running is not accepted and does not disturb the running burst.
- R12: A mode load during a burst does not change that burst's length or order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Mode-register load strobe |
| mode_bank | input | 2 | Bank select of the load; only 00 is taken |
| mode_word | input | MODE_W | Load word: bits 2:0 length code, bit 3 ordering |
| cfg_err | output | 1 | One-cycle pulse after a reserved length code |
| req_valid | input | 1 | Burst request valid |
| req_ready | output | 1 | Request can be taken |
| req_col | input | COL_W | Starting column of the burst |
| busy | output | 1 | A burst is in progress |
| beat_valid | output | 1 | Beat address valid |
| beat_ready | input | 1 | Consumer takes the beat |
| beat_col | output | COL_W | Column address of the current beat |
| beat_last | output | 1 | Current beat is the final one |

## Verification
Every start offset from 0 to 7 is tried under each of the six length and ordering combinations. Each request uses different upper column bits, so the runs separate the wrap-in-block ordering from the XOR ordering and from plain linear counting, and show whether the high bits leak. Some bursts are stalled on alternate beats to show that the held beat does not advance. Reserved length codes and nonzero bank selects are each followed by a burst, which shows whether the configuration changed. One burst carries a refused request and a mode load in its middle, which tells a clean refusal apart from a corrupted or restarted burst.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int IDX_W = 3;

  typedef enum logic [2:0] {
    LEN_2 = 3'b001,
    LEN_4 = 3'b010,
    LEN_8 = 3'b011
  } len_code_e;

  typedef enum logic {
    ORD_SEQ  = 1'b0,
    ORD_INTL = 1'b1
  } order_e;

  typedef struct packed {
    len_code_e len;
    order_e    ord;
  } burst_cfg_t;

  function automatic logic len_code_ok(input logic [2:0] c);
    return (c == LEN_2) || (c == LEN_4) || (c == LEN_8);
  endfunction
endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
  import bcs_pkg::*;
#(
  parameter int MODE_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [1:0]        bank,
  input  logic [MODE_W-1:0] word,
  output burst_cfg_t        cfg,
  output logic              err
);
  logic hit;
  assign hit = load && (bank == 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '{len: LEN_8, ord: ORD_SEQ};
      err <= 1'b0;
    end else begin
      err <= 1'b0;
      if (hit) begin
        if (len_code_ok(word[2:0])) begin
          cfg.len <= len_code_e'(word[2:0]);
          cfg.ord <= order_e'(word[3]);
        end else begin
          err <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bcs_beat_ctr.sv
module bcs_beat_ctr
  import bcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  len_code_e        len,
  input  logic             advance,
  output logic             active,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  logic [IDX_W-1:0] final_idx;

  always_comb begin
    case (len)
      LEN_2:   final_idx = IDX_W'(1);
      LEN_4:   final_idx = IDX_W'(3);
      default: final_idx = IDX_W'(7);
    endcase
  end

  assign last = active && (idx == final_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (start) begin
      active <= 1'b1;
      idx    <= '0;
    end else if (active && advance) begin
      if (last) begin
        active <= 1'b0;
        idx    <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
  import bcs_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base,
  input  len_code_e        len,
  input  order_e           ord,
  input  logic [IDX_W-1:0] idx,
  output logic [COL_W-1:0] col
);
  logic [1:0]       len_log;
  logic [IDX_W-1:0] seq_off;
  logic [IDX_W-1:0] xor_off;
  logic [IDX_W-1:0] off;
  logic [IDX_W-1:0] in_blk;

  assign len_log = len[1:0];
  assign seq_off = base[IDX_W-1:0] + idx;
  assign xor_off = base[IDX_W-1:0] ^ idx;
  assign off     = (ord == ORD_INTL) ? xor_off : seq_off;

  for (genvar b = 0; b < IDX_W; b++) begin : g_low
    assign in_blk[b] = (len_log > 2'(b));
    assign col[b]    = in_blk[b] ? off[b] : base[b];
  end

  assign col[COL_W-1:IDX_W] = base[COL_W-1:IDX_W];
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int MODE_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_load,
  input  logic [1:0]        mode_bank,
  input  logic [MODE_W-1:0] mode_word,
  output logic              cfg_err,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [COL_W-1:0]  req_col,
  output logic              busy,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [COL_W-1:0]  beat_col,
  output logic              beat_last
);
  burst_cfg_t       cfg_now;
  burst_cfg_t       cfg_run;
  logic [COL_W-1:0] base_q;
  logic             active;
  logic [IDX_W-1:0] idx;
  logic             take;

  assign take      = req_valid && req_ready;
  assign req_ready = !active;
  assign busy      = active;
  assign beat_valid = active;

  bcs_mode_reg #(.MODE_W(MODE_W)) u_mode (
    .clk  (clk),
    .rst_n(rst_n),
    .load (mode_load),
    .bank (mode_bank),
    .word (mode_word),
    .cfg  (cfg_now),
    .err  (cfg_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      cfg_run <= '{len: LEN_8, ord: ORD_SEQ};
    end else if (take) begin
      base_q  <= req_col;
      cfg_run <= cfg_now;
    end
  end

  bcs_beat_ctr u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (take),
    .len    (cfg_run.len),
    .advance(beat_ready),
    .active (active),
    .idx    (idx),
    .last   (beat_last)
  );

  bcs_addr_gen #(.COL_W(COL_W)) u_addr (
    .base(base_q),
    .len (cfg_run.len),
    .ord (cfg_run.ord),
    .idx (idx),
    .col (beat_col)
  );
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int COL_W  = 10,
  parameter int MODE_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_load,
  input logic [1:0]       mode_bank,
  input logic             cfg_err,
  input logic             req_valid,
  input logic             req_ready,
  input logic             busy,
  input logic             beat_valid,
  input logic             beat_ready,
  input logic [COL_W-1:0] beat_col,
  input logic             beat_last
);
  p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (beat_valid && busy));

  p_no_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> !req_ready);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=>
      (beat_valid && $stable(beat_col) && $stable(beat_last)));

  p_high_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && !beat_last) |=>
      (beat_valid && beat_col[COL_W-1:3] == $past(beat_col[COL_W-1:3])));

  p_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && beat_last) |=> !beat_valid);

  p_bank_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_load && mode_bank != 2'b00) |=> !cfg_err);
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W), .MODE_W(MODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_load (mode_load),
  .mode_bank (mode_bank),
  .cfg_err   (cfg_err),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .busy      (busy),
  .beat_valid(beat_valid),
  .beat_ready(beat_ready),
  .beat_col  (beat_col),
  .beat_last (beat_last)
);

// File: tb/sim_burst_col_seq.sv
module sim_burst_col_seq;
  localparam int COL_W  = 10;
  localparam int MODE_W = 13;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              mode_load;
  logic [1:0]        mode_bank;
  logic [MODE_W-1:0] mode_word;
  logic              cfg_err;
  logic              req_valid;
  logic              req_ready;
  logic [COL_W-1:0]  req_col;
  logic              busy;
  logic              beat_valid;
  logic              beat_ready;
  logic [COL_W-1:0]  beat_col;
  logic              beat_last;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int cur_len = 8;
  bit cur_intl = 0;

  always #10 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W), .MODE_W(MODE_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .mode_load(mode_load), .mode_bank(mode_bank), .mode_word(mode_word),
    .cfg_err(cfg_err),
    .req_valid(req_valid), .req_ready(req_ready), .req_col(req_col),
    .busy(busy),
    .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_col(beat_col), .beat_last(beat_last)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_col(input int col, input int len, input bit intl, input int i);
    int mask = len - 1;
    int off0 = col & mask;
    int off  = intl ? (off0 ^ i) : ((off0 + i) & mask);
    return (col & ~mask) | off;
  endfunction

  task automatic load_mode(input logic [1:0] bank, input logic [3:0] w);
    bit valid_code = (w[2:0] inside {3'b001, 3'b010, 3'b011});
    bit exp_err = (bank == 2'b00) && !valid_code;
    @(negedge clk);
    mode_load = 1'b1; mode_bank = bank; mode_word = MODE_W'(w);
    @(negedge clk);
    mode_load = 1'b0; mode_bank = 2'b00;
    if (bank != 2'b00)
      check(cfg_err == 1'b0, "R10 no error on other bank", int'(cfg_err), 0);
    else
      check(cfg_err == exp_err, "R9 error pulse", int'(cfg_err), int'(exp_err));
    if (exp_err) begin
      @(negedge clk);
      check(cfg_err == 1'b0, "R9 error lasts one cycle", int'(cfg_err), 0);
    end
    if (bank == 2'b00 && valid_code) begin
      cur_len  = 1 << w[1:0];
      cur_intl = w[3];
    end
  endtask

  // R3 R4 R5 R6 R7 via one burst; mid adds R11 and R12 stimulus
  task automatic burst(input int col, input bit stall, input bit mid);
    int len = cur_len;
    bit intl = cur_intl;
    int held;
    @(negedge clk);
    check(req_ready == 1'b1, "R2 ready when idle", int'(req_ready), 1);
    req_valid = 1'b1; req_col = COL_W'(col);
    @(negedge clk);
    req_valid = 1'b0;
    check(beat_valid && busy && !req_ready, "R2 burst started", int'(beat_valid), 1);
    for (int i = 0; i < len; i++) begin
      if (mid && i == 1) begin
        req_valid = 1'b1; req_col = COL_W'(col ^ 10'h155);
        mode_load = 1'b1; mode_bank = 2'b00; mode_word = MODE_W'(4'b0001);
        check(req_ready == 1'b0, "R11 request refused while busy", int'(req_ready), 0);
      end
      if (mid && i == 2) begin
        req_valid = 1'b0; mode_load = 1'b0;
      end
      if (stall && (i % 2 == 1)) begin
        beat_ready = 1'b0;
        held = int'(beat_col);
        @(negedge clk);
        check(beat_valid && int'(beat_col) == held, "R7 beat held under stall",
              int'(beat_col), held);
      end
      beat_ready = 1'b1;
      check(beat_valid == 1'b1, "R6 beat present", int'(beat_valid), 1);
      check(int'(beat_col) == exp_col(col, len, intl, i),
            intl ? "R4 R5 interleaved column" : "R3 R5 sequential column",
            int'(beat_col), exp_col(col, len, intl, i));
      check(beat_last == (i == len - 1), "R6 last flag", int'(beat_last), int'(i == len - 1));
      @(negedge clk);
      beat_ready = 1'b0;
    end
    check(beat_valid == 1'b0 && req_ready, "R6 burst ended after L beats", int'(beat_valid), 0);
    if (mid) begin
      mode_load = 1'b0; req_valid = 1'b0;
      cur_len = 2; cur_intl = 1'b0;
    end
  endtask

  initial begin
    rst_n = 1'b0; mode_load = 1'b0; mode_bank = 2'b00; mode_word = '0;
    req_valid = 1'b0; req_col = '0; beat_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!beat_valid && req_ready && !busy && !cfg_err, "R1 reset outputs",
          int'({beat_valid, req_ready, busy, cfg_err}), 4'b0100);
    burst(10'h2A5, 1'b0, 1'b0);   // R1 default length 8 sequential

    // R8 sweep of every valid configuration and every start offset
    for (int o = 0; o < 2; o++) begin
      for (int c = 1; c <= 3; c++) begin
        load_mode(2'b00, 4'(o * 8 + c));
        for (int s = 0; s < 8; s++)
          burst(((s * 37 + c * 91 + o * 300) % 128) * 8 + s, (s % 3 == 0), 1'b0);
      end
    end

    // R9 reserved codes leave config at length 4 interleaved
    load_mode(2'b00, 4'b1010);
    for (int c = 0; c < 8; c++) begin
      if (c >= 1 && c <= 3) continue;
      load_mode(2'b00, 4'(c));
      burst(10'h1F6 + c, 1'b0, 1'b0);
    end

    // R10 other banks ignored
    for (int b = 1; b < 4; b++) begin
      load_mode(2'(b), 4'b0011);
      burst(10'h0E3, 1'b1, 1'b0);
    end

    // R11 R12 refused request and mid-burst load, then new config applies
    load_mode(2'b00, 4'b1011);
    burst(10'h35D, 1'b0, 1'b1);
    burst(10'h35D, 1'b0, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule